// File: doc/BRIEF.md
# Block-replaying PE instruction sequencer

This block is the control path of one processing element in a SIMD array whose controller sends whole blocks of instructions rather than one instruction per cycle. The controller pushes instruction words through a write port, with a flag on the final word of each block. Words land in one of two local banks. A local program counter then runs the held block on the element's own clock.

Several virtual processing elements are folded onto this physical one through a K-by-K contraction. The sequencer therefore replays each block K*K times. Every issued word carries the row and column offset of the virtual element it serves. While one bank is executing, the controller fills the other bank, so a transfer overlaps the run before it. When the last pass of a block ends, the sequencer raises a barrier and waits for a global release before it moves to the next bank.

The load side is a two-state machine. LD_FILL stores words. LD_FILL goes to LD_DROP when an over-long block is detected and does not end on that word. LD_DROP returns to LD_FILL on the next accepted final word. The run side has three states. RN_IDLE goes to RN_ISSUE once its bank holds a complete block. RN_ISSUE loops back to itself with the counter reset to zero at the end of each non-final pass. RN_ISSUE goes to RN_WAIT after the final instruction of the final pass. RN_WAIT goes back to RN_IDLE on release, which frees the bank and selects the other one.

Top module: `pe_blk_seq`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), both banks are empty. iss_valid, barrier and wr_error are low, and wr_ready is high.
- R2: A word is taken at a clock edge where wr_valid and wr_ready are both high. A taken word with wr_last high closes the block in the current load bank, and the next block goes to the other bank. Bank 0 is filled first after reset.
- R3: wr_ready is low exactly while both banks hold blocks that have not yet been released.
- R4: A block starts to issue only after it is complete. When its final word is taken at edge E while the run side is idle, iss_valid is low in the cycle after E and high in the cycle after that.
- R5: Each pass issues the stored words in write order, one per cycle, with iss_valid high. There is no gap inside a block or between passes.
- R6: A block runs K*K passes. The column offset advances first and the row offset advances when the column wraps from K-1 to 0. Both start at 0. iss_last_pass is high only while the pass with row K-1 and column K-1 is issuing.
- R7: After the last word of the last pass, iss_valid goes low and barrier stays high until release_i is seen high at a clock edge. The bank is then freed and barrier drops. release_i has no effect outside the barrier state.
- R8: A one-word block runs correctly and issues K*K times.
- R9: A block of exactly DEPTH words is accepted and run. A block longer than DEPTH is rejected: wr_error is high for one cycle after word DEPTH+1 is taken, the rest of that block up to its final word is discarded, and nothing from it is issued.
- R10: While one bank is executing, the other bank accepts a new block, and that load completes without disturbing the issue stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing-element clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Controller offers an instruction word |
| wr_instr | input | IW | Instruction word offered |
| wr_last | input | 1 | Offered word ends its block |
| wr_ready | output | 1 | Load bank can take a word |
| wr_error | output | 1 | One-cycle pulse: block exceeded bank depth |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_instr | output | IW | Issued instruction |
| iss_row | output | KW | Row offset of the virtual element served |
| iss_col | output | KW | Column offset of the virtual element served |
| iss_last_pass | output | 1 | Issue belongs to the final pass |
| barrier | output | 1 | Block done, waiting for global release |
| release_i | input | 1 | Global barrier release |

## Verification
Two functions can land in the same cycle. The first is the write side taking, or closing, a block in one bank while the run side issues from the other bank. The second is the run side freeing a bank on release in the very cycle the write side resumes against a bank that has just been released. The bench provokes both by pushing the next block, and a third block behind it, while a long block is still replaying. It also uses an automatic release that fires as soon as the barrier appears. A behavioural queue model decides every cycle whether ready, issue fields and barrier are right, so any lost word, early start or missed stall shows up as a mismatch.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;
    typedef enum logic {
        LD_FILL,
        LD_DROP
    } load_state_t;

    typedef enum logic [1:0] {
        RN_IDLE,
        RN_ISSUE,
        RN_WAIT
    } run_state_t;
endpackage

// File: rtl/pe_blk_store.sv
module pe_blk_store #(
    parameter int IW    = 32,
    parameter int DEPTH = 128,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wbank,
    input  logic [AW-1:0] waddr,
    input  logic [IW-1:0] wdata,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [IW-1:0] rd_data
);
    logic [IW-1:0] mem [2][DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wbank][waddr] <= wdata;
    end

    assign rd_data = mem[rd_bank][rd_addr];
endmodule

// File: rtl/pe_blk_loader.sv
module pe_blk_loader
    import pe_seq_pkg::*;
#(
    parameter int IW    = 32,
    parameter int DEPTH = 128,
    parameter int AW    = 7,
    parameter int CW    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_valid,
    input  logic [IW-1:0]       wr_instr,
    input  logic                wr_last,
    output logic                wr_ready,
    output logic                wr_error,
    input  logic                free_valid,
    input  logic                free_bank,
    output logic [1:0]          bank_full,
    output logic [1:0][CW-1:0]  bank_len,
    output logic                we,
    output logic                wbank,
    output logic [AW-1:0]       waddr,
    output logic [IW-1:0]       wdata
);
    load_state_t ld_st, ld_nx;
    logic [CW-1:0] wcnt;
    logic          accept;
    logic          ovf;

    assign wr_ready = !bank_full[wbank];
    assign accept   = wr_valid && wr_ready;
    assign ovf      = (wcnt == CW'(DEPTH));
    assign waddr    = wcnt[AW-1:0];
    assign wdata    = wr_instr;

    always_ff @(posedge clk) begin
        if (rst) ld_st <= LD_FILL;
        else     ld_st <= ld_nx;
    end

    always_comb begin
        ld_nx = ld_st;
        we    = 1'b0;
        unique case (ld_st)
            LD_FILL: begin
                if (accept && ovf && !wr_last) ld_nx = LD_DROP;
                if (accept && !ovf)            we    = 1'b1;
            end
            LD_DROP: begin
                if (accept && wr_last) ld_nx = LD_FILL;
            end
            default: ld_nx = LD_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_full <= '0;
            bank_len  <= '0;
            wbank     <= 1'b0;
            wcnt      <= '0;
            wr_error  <= 1'b0;
        end else begin
            wr_error <= 1'b0;
            if (free_valid) bank_full[free_bank] <= 1'b0;
            if (ld_st == LD_FILL && accept) begin
                if (ovf) begin
                    wr_error <= 1'b1;
                    wcnt     <= '0;
                end else if (wr_last) begin
                    bank_full[wbank] <= 1'b1;
                    bank_len[wbank]  <= wcnt + CW'(1);
                    wbank            <= ~wbank;
                    wcnt             <= '0;
                end else begin
                    wcnt <= wcnt + CW'(1);
                end
            end
        end
    end

    a_r3_write_free_bank: assert property (@(posedge clk) disable iff (rst)
        we |-> !bank_full[wbank]);

    a_r9_error_after_full_count: assert property (@(posedge clk) disable iff (rst)
        wr_error |-> $past(wcnt) == CW'(DEPTH));

    for (genvar b = 0; b < 2; b++) begin : g_bank_chk
        a_r2_len_in_range: assert property (@(posedge clk) disable iff (rst)
            bank_full[b] |-> (bank_len[b] != '0 && bank_len[b] <= CW'(DEPTH)));
    end
endmodule

// File: rtl/pe_blk_runner.sv
module pe_blk_runner
    import pe_seq_pkg::*;
#(
    parameter int K  = 2,
    parameter int AW = 7,
    parameter int CW = 8,
    parameter int KW = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          bank_full,
    input  logic [1:0][CW-1:0]  bank_len,
    input  logic                release_i,
    output logic                rd_bank,
    output logic [AW-1:0]       rd_addr,
    output logic                iss_valid,
    output logic [KW-1:0]       iss_row,
    output logic [KW-1:0]       iss_col,
    output logic                iss_last_pass,
    output logic                barrier,
    output logic                free_valid,
    output logic                free_bank
);
    run_state_t    st, nx;
    logic          ebank;
    logic [AW-1:0] pc;
    logic [KW-1:0] row, col;
    logic [CW-1:0] cur_len;
    logic          blk_end;
    logic          final_pass;

    assign cur_len    = bank_len[ebank];
    assign blk_end    = (CW'(pc) == cur_len - CW'(1));
    assign final_pass = (row == KW'(K - 1)) && (col == KW'(K - 1));

    always_ff @(posedge clk) begin
        if (rst) st <= RN_IDLE;
        else     st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            RN_IDLE:  if (bank_full[ebank])       nx = RN_ISSUE;
            RN_ISSUE: if (blk_end && final_pass)  nx = RN_WAIT;
            RN_WAIT:  if (release_i)              nx = RN_IDLE;
            default:                              nx = RN_IDLE;
        endcase
    end

    always_comb begin
        iss_valid     = (st == RN_ISSUE);
        barrier       = (st == RN_WAIT);
        free_valid    = (st == RN_WAIT) && release_i;
        free_bank     = ebank;
        iss_last_pass = (st == RN_ISSUE) && final_pass;
        rd_bank       = ebank;
        rd_addr       = pc;
        iss_row       = row;
        iss_col       = col;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ebank <= 1'b0;
            pc    <= '0;
            row   <= '0;
            col   <= '0;
        end else begin
            unique case (st)
                RN_IDLE: begin
                    pc  <= '0;
                    row <= '0;
                    col <= '0;
                end
                RN_ISSUE: begin
                    if (blk_end) begin
                        pc <= '0;
                        if (col == KW'(K - 1)) begin
                            col <= '0;
                            row <= final_pass ? '0 : row + KW'(1);
                        end else begin
                            col <= col + KW'(1);
                        end
                    end else begin
                        pc <= pc + AW'(1);
                    end
                end
                RN_WAIT: if (release_i) ebank <= ~ebank;
                default: ;
            endcase
        end
    end

    a_r4_issue_needs_full_bank: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> bank_full[rd_bank]);

    a_r5_addr_inside_block: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> CW'(rd_addr) < bank_len[rd_bank]);

    a_r7_barrier_holds: assert property (@(posedge clk) disable iff (rst)
        barrier && !release_i |=> barrier && !iss_valid);

    a_r6_pass_restarts: assert property (@(posedge clk) disable iff (rst)
        iss_valid && blk_end && !final_pass |=> iss_valid && rd_addr == '0);
endmodule

// File: rtl/pe_blk_seq.sv
module pe_blk_seq #(
    parameter int IW    = 32,
    parameter int DEPTH = 128,
    parameter int K     = 2,
    localparam int KW   = (K > 1) ? $clog2(K) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [IW-1:0] wr_instr,
    input  logic          wr_last,
    output logic          wr_ready,
    output logic          wr_error,
    output logic          iss_valid,
    output logic [IW-1:0] iss_instr,
    output logic [KW-1:0] iss_row,
    output logic [KW-1:0] iss_col,
    output logic          iss_last_pass,
    output logic          barrier,
    input  logic          release_i
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [1:0]         bank_full;
    logic [1:0][CW-1:0] bank_len;
    logic               free_valid, free_bank;
    logic               we, wbank, rd_bank;
    logic [AW-1:0]      waddr, rd_addr;
    logic [IW-1:0]      wdata;

    pe_blk_loader #(.IW(IW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_loader (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_instr(wr_instr), .wr_last(wr_last),
        .wr_ready(wr_ready), .wr_error(wr_error),
        .free_valid(free_valid), .free_bank(free_bank),
        .bank_full(bank_full), .bank_len(bank_len),
        .we(we), .wbank(wbank), .waddr(waddr), .wdata(wdata)
    );

    pe_blk_store #(.IW(IW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .we(we), .wbank(wbank), .waddr(waddr), .wdata(wdata),
        .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(iss_instr)
    );

    pe_blk_runner #(.K(K), .AW(AW), .CW(CW), .KW(KW)) u_runner (
        .clk(clk), .rst(rst),
        .bank_full(bank_full), .bank_len(bank_len), .release_i(release_i),
        .rd_bank(rd_bank), .rd_addr(rd_addr),
        .iss_valid(iss_valid), .iss_row(iss_row), .iss_col(iss_col),
        .iss_last_pass(iss_last_pass), .barrier(barrier),
        .free_valid(free_valid), .free_bank(free_bank)
    );
endmodule

// File: tb/pe_blk_seq_tb_top.sv
module pe_blk_seq_tb_top;
    localparam int IW    = 32;
    localparam int DEPTH = 128;
    localparam int K     = 2;
    localparam int KW    = (K > 1) ? $clog2(K) : 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [IW-1:0] wr_instr = '0;
    logic          wr_last = 1'b0;
    logic          wr_ready, wr_error;
    logic          iss_valid, iss_last_pass, barrier;
    logic [IW-1:0] iss_instr;
    logic [KW-1:0] iss_row, iss_col;
    logic          man_rel = 1'b0;
    logic          auto_pulse = 1'b0;
    logic          auto_rel = 1'b0;
    logic          release_i;

    assign release_i = man_rel | auto_pulse;

    always #10 clk = ~clk;

    pe_blk_seq #(.IW(IW), .DEPTH(DEPTH), .K(K)) dut_i (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_instr(wr_instr), .wr_last(wr_last),
        .wr_ready(wr_ready), .wr_error(wr_error),
        .iss_valid(iss_valid), .iss_instr(iss_instr),
        .iss_row(iss_row), .iss_col(iss_col),
        .iss_last_pass(iss_last_pass), .barrier(barrier),
        .release_i(release_i)
    );

    int checks = 0;
    int errors = 0;
    int iss_cnt = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference: queues of completed blocks and a staging queue
    int            m_st = 0;          // 0 idle, 1 issuing, 2 barrier
    int            m_pc = 0, m_row = 0, m_col = 0;
    int            occ_len[$];
    logic [IW-1:0] m_flat[$];
    logic [IW-1:0] m_stage[$];
    bit            m_drop = 0;
    bit            m_err = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_pc = 0; m_row = 0; m_col = 0;
            occ_len.delete(); m_flat.delete(); m_stage.delete();
            m_drop = 0; m_err = 0;
        end else begin
            bit rdy;
            rdy   = (occ_len.size() < 2);
            m_err = 0;
            case (m_st)
                0: if (occ_len.size() >= 1) begin
                    m_st = 1; m_pc = 0; m_row = 0; m_col = 0;
                end
                1: if (m_pc == occ_len[0] - 1) begin
                    m_pc = 0;
                    if (m_col == K - 1) begin
                        m_col = 0;
                        if (m_row == K - 1) begin m_row = 0; m_st = 2; end
                        else m_row++;
                    end else m_col++;
                end else m_pc++;
                default: if (release_i) begin
                    for (int i = 0; i < occ_len[0]; i++) void'(m_flat.pop_front());
                    void'(occ_len.pop_front());
                    m_st = 0;
                end
            endcase
            if (wr_valid && rdy) begin
                if (m_drop) begin
                    if (wr_last) m_drop = 0;
                end else if (m_stage.size() == DEPTH) begin
                    m_err = 1;
                    m_stage.delete();
                    m_drop = !wr_last;
                end else begin
                    m_stage.push_back(wr_instr);
                    if (wr_last) begin
                        foreach (m_stage[i]) m_flat.push_back(m_stage[i]);
                        occ_len.push_back(m_stage.size());
                        m_stage.delete();
                    end
                end
            end
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(wr_ready == (occ_len.size() < 2), "R3", "wr_ready", wr_ready, occ_len.size() < 2);
            chk(iss_valid == (m_st == 1), "R5", "iss_valid", iss_valid, m_st == 1);
            chk(barrier == (m_st == 2), "R7", "barrier", barrier, m_st == 2);
            chk(wr_error == m_err, "R9", "wr_error", wr_error, m_err);
            if (m_st == 1) begin
                chk(iss_instr == m_flat[m_pc], "R5", "iss_instr", iss_instr, m_flat[m_pc]);
                chk(iss_row == KW'(m_row), "R6", "iss_row", iss_row, m_row);
                chk(iss_col == KW'(m_col), "R6", "iss_col", iss_col, m_col);
                chk(iss_last_pass == (m_row == K - 1 && m_col == K - 1), "R6", "iss_last_pass",
                    iss_last_pass, m_row == K - 1 && m_col == K - 1);
            end else begin
                chk(iss_last_pass == 1'b0, "R6", "iss_last_pass idle", iss_last_pass, 0);
            end
            if (iss_valid) iss_cnt++;
        end
        auto_pulse = auto_rel && barrier && !auto_pulse;
    end

    task automatic send_block(int len, int base);
        for (int i = 0; i < len; i++) begin
            wr_valid = 1'b1;
            wr_instr = IW'(base + i);
            wr_last  = (i == len - 1);
            while (!wr_ready) @(negedge clk);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        wr_last  = 1'b0;
    endtask

    task automatic wait_barrier();
        while (!barrier) @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(iss_valid == 0, "R1", "iss_valid", iss_valid, 0);
        chk(barrier == 0, "R1", "barrier", barrier, 0);
        chk(wr_ready == 1, "R1", "wr_ready", wr_ready, 1);
        chk(wr_error == 0, "R1", "wr_error", wr_error, 0);

        // R4 / R8: single-word block
        auto_rel = 1'b1;
        iss_cnt = 0;
        send_block(1, 'h100);
        chk(iss_valid == 0, "R4", "iss_valid one cycle after load", iss_valid, 0);
        @(negedge clk);
        chk(iss_valid == 1, "R4", "iss_valid two cycles after load", iss_valid, 1);
        wait_barrier();
        @(negedge clk);
        chk(iss_cnt == K * K, "R8", "single-word issue count", iss_cnt, K * K);

        // R10 / R2 / R3: overlapped loads
        repeat (3) @(negedge clk);
        iss_cnt = 0;
        send_block(20, 'h200);
        send_block(7, 'h300);
        chk(iss_valid == 1 && barrier == 0, "R10", "load overlapped run", iss_valid, 1);
        chk(wr_ready == 0, "R3", "both banks held", wr_ready, 0);
        send_block(3, 'h400);
        repeat (200) @(negedge clk);
        chk(iss_cnt == 30 * K * K, "R2", "three blocks issued", iss_cnt, 30 * K * K);

        // R7: barrier holds without release; release ignored elsewhere
        auto_rel = 1'b0;
        send_block(2, 'h500);
        wait_barrier();
        repeat (5) @(negedge clk);
        chk(barrier == 1 && iss_valid == 0, "R7", "barrier held", barrier, 1);
        man_rel = 1'b1;
        @(negedge clk);
        man_rel = 1'b0;
        chk(barrier == 0, "R7", "barrier dropped on release", barrier, 0);
        man_rel = 1'b1;
        repeat (3) @(negedge clk);
        man_rel = 1'b0;
        chk(barrier == 0 && iss_valid == 0, "R7", "release while idle", iss_valid, 0);
        iss_cnt = 0;
        send_block(5, 'h600);
        @(negedge clk);
        man_rel = 1'b1;
        repeat (4) @(negedge clk);
        man_rel = 1'b0;
        wait_barrier();
        chk(iss_cnt == 5 * K * K, "R7", "release during run ignored", iss_cnt, 5 * K * K);
        auto_rel = 1'b1;
        repeat (4) @(negedge clk);

        // R9: over-long blocks rejected, exact depth accepted
        iss_cnt = 0;
        send_block(DEPTH + 1, 'h1000);
        chk(wr_error == 1, "R9", "error pulse", wr_error, 1);
        @(negedge clk);
        chk(wr_error == 0, "R9", "error single cycle", wr_error, 0);
        send_block(DEPTH + 3, 'h3000);
        repeat (10) @(negedge clk);
        chk(iss_cnt == 0 && iss_valid == 0, "R9", "rejected block not issued", iss_cnt, 0);
        send_block(DEPTH, 'h2000);
        wait_barrier();
        @(negedge clk);
        chk(iss_cnt == DEPTH * K * K, "R9", "full-depth block issued", iss_cnt, DEPTH * K * K);

        repeat (20) @(negedge clk);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule